// File: doc/BRIEF.md
# Fourth-Order Integrator-Comb Rate Reducer

This block takes a multi-bit oversampled noise-shaped stream, one 4-bit two's-complement sample per clock, and lowers the sample rate by sixteen. Its response equals four cascaded sixteen-tap running sums, (1 - z^-16)/(1 - z^-1) raised to the fourth power. A typical use is turning a 3.072 MHz stream into 192 kHz words for the sharper filter stages that follow.

Four accumulators run on every clock. Each one is a register that feeds the next, so the adder path between flops is a single stage. A phase counter picks one clock in sixteen. On that clock, four differencing stages update. The 20-bit difference result has its four low bits dropped, and the top sixteen bits are presented with a one-cycle valid pulse.

The internal width is exactly the input width plus four times log2 of sixteen, which is 20 bits. All sums wrap modulo 2^20 and never saturate. Because the end-to-end gain is 2^16, the wrapped values cancel in the differencing stages. The final result is therefore exact.

Top module: `cic_decimator`

## Requirements
- R1: While `rst` is high, and after its release until the first valid pulse, `data_out` is 0 and `out_valid` is 0.
- R2: `out_valid` is high for exactly one cycle at a time. Count the first clock edge with `rst` low as sample 0. The first pulse appears in the cycle after sample 15, and later pulses come exactly 16 cycles apart.
- R3: Take the pulse in the cycle after sample n, where n = 16m + 15. During that pulse, `data_out` (read as signed) equals floor(y / 16), where y is the sum over k = 0..60 of h[k] * x[n-4-k]. Here h is the fourfold self-convolution of a length-16 all-ones sequence, and x is zero before sample 0.
- R4: `din` is read as 4-bit two's complement: 4'b1000 is -8 and 4'b0111 is +7. A constant input x held long after reset gives `data_out` = x * 4096. This is -32768 for -8 and 28672 for +7, and it stays exact even though the internal accumulators wrap.
- R5: Between valid pulses, `data_out` holds the value of the most recent pulse.
- R6: Asserting `rst` in the middle of a stream discards all prior history. Later outputs follow R3 as if every earlier input were zero.
- R7: For any input sequence, the signed `data_out` stays within -32768 to 28672.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 4 | Modulator sample, two's complement, one per clock |
| data_out | output | 16 | Top 16 bits of the 20-bit filtered result, two's complement |
| out_valid | output | 1 | One-cycle pulse marking a new `data_out` word |

## Verification
The assertions take for granted that `din` carries a known 4-bit code on every clock with `rst` low. They also assume that `rst` is high from time zero for at least one clock edge. The output bound in R7 rests on a further fact: every 4-bit code lies between -8 and +7, and all filter taps are non-negative. The stimulus uses only legal codes, driven on the falling edge: held extremes, alternating extremes, a unit impulse and a pseudo-random sequence. Each scenario starts from a multi-cycle reset, and one of them follows a stream that was cut off partway.

// File: rtl/cic_dec_pkg.sv
package cic_dec_pkg;

  // Strobes from the phase control to the datapath.
  typedef struct packed {
    logic combEn;   // low-rate tick: difference stages and output register update
  } cicStrobes_t;

endpackage

// File: rtl/cic_dec_ctrl.sv
module cic_dec_ctrl
  import cic_dec_pkg::*;
#(
  parameter int DECIM = 16
) (
  input  logic        clk,
  input  logic        rst,
  output cicStrobes_t strobes
);

  localparam int PHASE_W = $clog2(DECIM);
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(DECIM - 1);

  logic [PHASE_W-1:0] phaseQ;

  // DECIM is a power of two, so the phase wraps naturally.
  always_ff @(posedge clk) begin
    if (rst) phaseQ <= '0;
    else     phaseQ <= phaseQ + 1'b1;
  end

  always_comb begin
    strobes.combEn = (phaseQ == LAST_PHASE);
  end

endmodule

// File: rtl/cic_dec_dp.sv
module cic_dec_dp
  import cic_dec_pkg::*;
#(
  parameter int IN_W  = 4,
  parameter int ORDER = 4,
  parameter int DECIM = 16,
  parameter int OUT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  cicStrobes_t       strobes,
  input  logic [IN_W-1:0]   din,
  output logic [OUT_W-1:0]  dataOut,
  output logic              outValid
);

  localparam int LOG2D = $clog2(DECIM);
  localparam int ACC_W = IN_W + ORDER * LOG2D;
  localparam int DROP  = ACC_W - OUT_W;

  logic [ACC_W-1:0] dinExt;
  logic [ACC_W-1:0] integOut  [ORDER];
  logic [ACC_W-1:0] combChain [ORDER+1];

  assign dinExt = {{(ACC_W-IN_W){din[IN_W-1]}}, din};

  // Accumulator cascade: each stage adds the registered output of the one before.
  for (genvar g = 0; g < ORDER; g++) begin : g_integ
    logic [ACC_W-1:0] accQ;
    logic [ACC_W-1:0] accIn;
    if (g == 0) begin : g_first
      assign accIn = dinExt;
    end else begin : g_next
      assign accIn = integOut[g-1];
    end
    always_ff @(posedge clk) begin
      if (rst) accQ <= '0;
      else     accQ <= accQ + accIn;
    end
    assign integOut[g] = accQ;
  end

  assign combChain[0] = integOut[ORDER-1];

  // Differencing cascade at the low rate, one delay register per stage.
  for (genvar g = 0; g < ORDER; g++) begin : g_comb
    logic [ACC_W-1:0] dlyQ;
    always_ff @(posedge clk) begin
      if (rst)                 dlyQ <= '0;
      else if (strobes.combEn) dlyQ <= combChain[g];
    end
    assign combChain[g+1] = combChain[g] - dlyQ;
  end

  logic [OUT_W-1:0] outQ;
  logic             validQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      outQ   <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= strobes.combEn;
      if (strobes.combEn) outQ <= OUT_W'(combChain[ORDER] >> DROP);
    end
  end

  assign dataOut  = outQ;
  assign outValid = validQ;

endmodule

// File: rtl/cic_decimator.sv
module cic_decimator
  import cic_dec_pkg::*;
#(
  parameter int IN_W  = 4,
  parameter int ORDER = 4,
  parameter int DECIM = 16,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] data_out,
  output logic             out_valid
);

  cicStrobes_t strobes;

  cic_dec_ctrl #(.DECIM(DECIM)) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes)
  );

  cic_dec_dp #(
    .IN_W  (IN_W),
    .ORDER (ORDER),
    .DECIM (DECIM),
    .OUT_W (OUT_W)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .din      (din),
    .dataOut  (data_out),
    .outValid (out_valid)
  );

endmodule

// File: rtl/cic_decimator_chk.sv
module cic_decimator_chk #(
  parameter int IN_W  = 4,
  parameter int ORDER = 4,
  parameter int DECIM = 16,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [IN_W-1:0]  din,
  input logic [OUT_W-1:0] data_out,
  input logic             out_valid
);

  localparam int LOG2D  = $clog2(DECIM);
  localparam int ACC_W  = IN_W + ORDER * LOG2D;
  localparam int GAIN_W = ORDER * LOG2D - (ACC_W - OUT_W);
  localparam int MAXOUT = ((2 ** (IN_W - 1)) - 1) * (2 ** GAIN_W);
  localparam int MINOUT = -(2 ** (IN_W - 1)) * (2 ** GAIN_W);
  localparam int CNT_W  = LOG2D + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Cycles since reset release or since the last pulse (saturating).
  logic [CNT_W-1:0] sinceV;
  always_ff @(posedge clk) begin
    if (rst)                  sinceV <= '0;
    else if (out_valid)       sinceV <= CNT_W'(1);
    else if (sinceV != CNT_MAX) sinceV <= sinceV + 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (data_out == '0 && !out_valid));

  p_pulse_single_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  p_pulse_period_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (sinceV == CNT_W'(DECIM)));

  p_pulse_not_late_r2: assert property (@(posedge clk) disable iff (rst)
    sinceV <= CNT_W'(DECIM));

  p_hold_between_r5: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(data_out));

  p_output_bound_r7: assert property (@(posedge clk) disable iff (rst)
    (int'($signed(data_out)) <= MAXOUT) && (int'($signed(data_out)) >= MINOUT));

  p_input_known_r4: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(din));

endmodule

bind cic_decimator cic_decimator_chk #(
  .IN_W  (IN_W),
  .ORDER (ORDER),
  .DECIM (DECIM),
  .OUT_W (OUT_W)
) chk_i (.*);

// File: tb/cic_decimator_tb_top.sv
`timescale 1ns/1ps
module cic_decimator_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  din = 4'd0;
  logic [15:0] data_out;
  logic        out_valid;

  int nChecks = 0;
  int nFails  = 0;
  int xs [0:1023];
  int h  [0:60];
  int lastOut;
  int seed = 12345;

  always #4 clk = ~clk;

  cic_decimator dut_i (
    .clk       (clk),
    .rst       (rst),
    .din       (din),
    .data_out  (data_out),
    .out_valid (out_valid)
  );

  task automatic checkVal(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Fourfold convolution of a 16-long all-ones sequence.
  task automatic buildKernel();
    int a [0:60];
    int b [0:60];
    for (int i = 0; i < 61; i++) a[i] = (i < 16) ? 1 : 0;
    for (int s = 1; s < 4; s++) begin
      for (int i = 0; i < 61; i++) begin
        b[i] = 0;
        for (int j = 0; j < 16; j++) if (i - j >= 0) b[i] += a[i-j];
      end
      for (int i = 0; i < 61; i++) a[i] = b[i];
    end
    for (int i = 0; i < 61; i++) h[i] = a[i];
  endtask

  function automatic int refOut(input int j);
    int y = 0;
    for (int k = 0; k < 61; k++) if (j - k >= 0) y += h[k] * xs[j-k];
    return y >>> 4;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    din = 4'd0;
    repeat (3) @(negedge clk);
    checkVal("R1", "data_out in reset", int'($signed(data_out)), 0);
    checkVal("R1", "out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    lastOut = 0;
  endtask

  // kind: 0 hold +7, 1 hold -8, 2 alternate +7/-8, 3 impulse +1, 4 pseudo-random
  task automatic runStream(input int kind, input int nSamp, input string req);
    for (int n = 0; n < nSamp; n++) begin
      case (kind)
        0: xs[n] = 7;
        1: xs[n] = -8;
        2: xs[n] = (n % 2 == 0) ? 7 : -8;
        3: xs[n] = (n == 0) ? 1 : 0;
        default: begin
          seed = seed * 1103515245 + 12345;
          xs[n] = ((seed >>> 16) & 15) - 8;
        end
      endcase
    end
    doReset();
    for (int n = 0; n < nSamp; n++) begin
      din = 4'(xs[n]);
      @(negedge clk);
      if (n % 16 == 15) begin
        checkVal("R2", "out_valid on pulse", int'(out_valid), 1);
        checkVal(req, "data_out on pulse", int'($signed(data_out)), refOut(n - 4));
        lastOut = refOut(n - 4);
      end else begin
        checkVal("R2", "out_valid between pulses", int'(out_valid), 0);
        checkVal((n < 15) ? "R1" : "R5", "data_out hold", int'($signed(data_out)), lastOut);
      end
    end
  endtask

  task automatic testDcPositive();
    runStream(0, 320, "R4");
    checkVal("R4", "settled +7", int'($signed(data_out)), 28672);
  endtask

  task automatic testDcNegative();
    runStream(1, 320, "R4");
    checkVal("R4", "settled -8", int'($signed(data_out)), -32768);
  endtask

  task automatic testImpulse();
    runStream(3, 96, "R3");
  endtask

  task automatic testAlternate();
    runStream(2, 160, "R3");
  endtask

  task automatic testRandom();
    runStream(4, 400, "R7");
  endtask

  task automatic testMidReset();
    runStream(0, 40, "R4");
    runStream(3, 64, "R6");
  endtask

  initial begin
    buildKernel();
    testDcPositive();
    testDcNegative();
    testImpulse();
    testAlternate();
    testRandom();
    testMidReset();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule